// File: doc/BRIEF.md
# Crash Dump Capture and Readout

This block keeps a multi-word diagnostic snapshot, for example of alert or processor status, taken at the moment a system reset occurs. The snapshot survives the system reset because the block sits on its own, longer-lived reset. Software reads it back one 32-bit word at a time. It first selects a word through an index field in a control register, then reads a data register.

Software arms a capture by setting an enable bit. Hardware clears that bit on every system-reset pulse, so each armed capture records at most one event. A lock register can close the control register against further writes. Once closed, it stays closed until the block's own reset.

Register access goes through a request channel and a response channel, each with a valid/ready handshake. A request moves when `req_valid` and `req_ready` are both high. Every accepted request produces exactly one response beat on the following cycle. A response is held, with its data unchanged, until `rsp_ready` is high. `req_ready` is low while a response is pending and `rsp_ready` is low, so a stalled consumer stalls the request side with no loss. Register map by `req_addr`: 0 lock, 1 control, 2 word count, 3 data.

Top module: `crash_dump_unit`

## Requirements
- R1: After `rst_n`, the lock register reads 1, the control register reads 0, the data register reads 0 and `rsp_valid` is low.
- R2: The count register (address 2) reads the parameter WORDS in bits 3:0, with all higher bits zero, whatever has been written.
- R3: A `sys_rst_pulse` cycle in which the capture enable (control bit 0) is 1 latches the whole dump vector. Afterwards, the data register (address 3) returns the word selected by the control index (bits 7:4), with word n being `dump_i[32n+31:32n]`.
- R4: Every `sys_rst_pulse` cycle clears the capture enable. When a control write setting the enable is accepted in the same cycle, the enable still ends at 0 and no capture happens.
- R5: A `sys_rst_pulse` cycle with the capture enable at 0 leaves the stored snapshot unchanged.
- R6: An index equal to or above WORDS reads the data register as zero.
- R7: Writing the lock register with bit 0 = 0 clears it. Writing 1 afterwards does not set it again.
- R8: While the lock register is 0, writes to the control register change neither the enable nor the index.
- R9: An accepted request yields `rsp_valid` on the next cycle. A response waiting with `rsp_ready` low keeps `rsp_valid` and `rsp_rdata` stable and holds `req_ready` low. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of this block (not the system reset) |
| sys_rst_pulse | input | 1 | One-cycle system reset indication |
| dump_i | input | 32*WORDS | Diagnostic state to snapshot |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (zero for writes) |

## Verification
Two events can fall in the same cycle: a software write that arms the capture, and a system-reset pulse that clears it. The bench provokes this by presenting the control write and the pulse before the same clock edge. It then judges the result from the ports. A control read must show the enable at 0, and a data read must still return the earlier snapshot, even though a different dump vector was on the input. A second overlap places a stalled response next to a new request, and checks that the request waits and the held data does not move.

// File: rtl/cdump_pkg.sv
package cdump_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_IDX_LSB = 4;

  typedef enum logic [1:0] {
    ADDR_LOCK  = 2'd0,
    ADDR_CTRL  = 2'd1,
    ADDR_COUNT = 2'd2,
    ADDR_DATA  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cdump_ctrl_regs.sv
module cdump_ctrl_regs
  import cdump_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lock,
  input  logic              wr_ctrl,
  input  logic [WORD_W-1:0] wdata,
  input  logic              sys_rst_pulse,
  output logic              lock_o,
  output logic              en_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic             lock_q, en_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      en_q   <= 1'b0;
      idx_q  <= '0;
    end else begin
      if (wr_lock && !wdata[0]) lock_q <= 1'b0;
      if (wr_ctrl && lock_q) begin
        en_q  <= wdata[CTRL_EN_BIT];
        idx_q <= wdata[CTRL_IDX_LSB +: IDX_W];
      end
      // system reset disarms capture and wins over a same-cycle write
      if (sys_rst_pulse) en_q <= 1'b0;
    end
  end

  assign lock_o = lock_q;
  assign en_o   = en_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/cdump_store.sv
module cdump_store
  import cdump_pkg::*;
#(
  parameter int unsigned WORDS = 10,
  parameter int unsigned IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic [WORDS*WORD_W-1:0] dump_i,
  input  logic [IDX_W-1:0]        idx,
  output logic [WORD_W-1:0]       word_o
);
  logic [WORD_W-1:0] snap_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap_q[w] <= '0;
      else if (capture) snap_q[w] <= dump_i[w*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (idx == IDX_W'(i)) word_o = snap_q[i];
    end
  end
endmodule

// File: rtl/cdump_reg_port.sv
module cdump_reg_port
  import cdump_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned WORDS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              wr_lock,
  output logic              wr_ctrl,
  input  logic              lock,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] data_word
);
  localparam logic [IDX_W-1:0] CNT = IDX_W'(WORDS);

  logic              accept;
  logic [WORD_W-1:0] rd_mux;
  logic              vld_q;
  logic [WORD_W-1:0] dat_q;

  assign req_ready = !vld_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_lock   = accept && req_write && (req_addr == ADDR_LOCK);
  assign wr_ctrl   = accept && req_write && (req_addr == ADDR_CTRL);

  always_comb begin
    rd_mux = '0;
    if (!req_write) begin
      unique case (reg_addr_e'(req_addr))
        ADDR_LOCK:  rd_mux[0] = lock;
        ADDR_CTRL: begin
          rd_mux[CTRL_EN_BIT]              = en;
          rd_mux[CTRL_IDX_LSB +: IDX_W]    = idx;
        end
        ADDR_COUNT: rd_mux[IDX_W-1:0] = CNT;
        ADDR_DATA:  rd_mux = data_word;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      dat_q <= rd_mux;
    end else if (rsp_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_rdata = dat_q;
endmodule

// File: rtl/crash_dump_unit.sv
module crash_dump_unit
  import cdump_pkg::*;
#(
  parameter int unsigned WORDS = 10,
  parameter int unsigned IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sys_rst_pulse,
  input  logic [WORDS*WORD_W-1:0] dump_i,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [1:0]              req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [WORD_W-1:0]       rsp_rdata
);
  logic              wr_lock, wr_ctrl, lock, cap_en;
  logic [IDX_W-1:0]  sel_idx;
  logic [WORD_W-1:0] data_word;

  cdump_ctrl_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_lock(wr_lock), .wr_ctrl(wr_ctrl),
    .wdata(req_wdata), .sys_rst_pulse(sys_rst_pulse),
    .lock_o(lock), .en_o(cap_en), .idx_o(sel_idx)
  );

  cdump_store #(.WORDS(WORDS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .capture(sys_rst_pulse && cap_en),
    .dump_i(dump_i), .idx(sel_idx), .word_o(data_word)
  );

  cdump_reg_port #(.IDX_W(IDX_W), .WORDS(WORDS)) u_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .wr_lock(wr_lock), .wr_ctrl(wr_ctrl), .lock(lock), .en(cap_en),
    .idx(sel_idx), .data_word(data_word)
  );
endmodule

// File: rtl/crash_dump_unit_chk.sv
module crash_dump_unit_chk #(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_rst_pulse,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata,
  input logic             lock,
  input logic             cap_en,
  input logic [IDX_W-1:0] sel_idx
);
  assert_en_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |=> !cap_en);
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> !lock);
  assert_ctrl_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock && !sys_rst_pulse) |=> ($stable(cap_en) && $stable(sel_idx)));
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  assert_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

bind crash_dump_unit crash_dump_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst_pulse(sys_rst_pulse),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .lock(lock),
  .cap_en(cap_en), .sel_idx(sel_idx)
);

// File: tb/crash_dump_unit_tb_top.sv
`timescale 1ns/1ps
module crash_dump_unit_tb_top;
  localparam int WORDS = 10;

  function automatic logic [31:0] pat(input int i);
    return (32'h1000_0001 * (i + 1)) ^ 32'hC3C3_0000;
  endfunction

  typedef struct packed { logic [3:0] idx; logic [31:0] exp; } vec_t;
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{4'd0, pat(0)}, '{4'd9, pat(9)}, '{4'd3, pat(3)}, '{4'd1, pat(1)},
    '{4'd8, pat(8)}, '{4'd10, 32'h0}, '{4'd5, pat(5)}, '{4'd15, 32'h0},
    '{4'd2, pat(2)}, '{4'd7, pat(7)}, '{4'd4, pat(4)}, '{4'd6, pat(6)}
  };

  logic clk = 0, rst_n = 0, sys_rst_pulse = 0;
  logic [WORDS*32-1:0] dump_i = '0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  int n_vec = 0, n_bad = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  crash_dump_unit #(.WORDS(WORDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .sys_rst_pulse(sys_rst_pulse), .dump_i(dump_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] a, input logic [31:0] d,
                        output logic [31:0] r);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    r = rsp_rdata;
  endtask

  task automatic pulse_sys();
    @(negedge clk); sys_rst_pulse = 1;
    @(negedge clk); sys_rst_pulse = 0;
  endtask

  function automatic logic [WORDS*32-1:0] make_dump(input logic [31:0] x);
    logic [WORDS*32-1:0] v;
    for (int i = 0; i < WORDS; i++) v[i*32 +: 32] = pat(i) ^ x;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    access(0, 2'd0, 0, rd); check("R1 lock", rd, 32'h1);
    access(0, 2'd1, 0, rd); check("R1 ctrl", rd, 32'h0);
    access(0, 2'd3, 0, rd); check("R1 data", rd, 32'h0);
    access(0, 2'd2, 0, rd); check("R2 count", rd, 32'd10);
    access(1, 2'd2, 32'hFFFF_FFFF, rd); check("R9 write rsp zero", rd, 32'h0);
    access(0, 2'd2, 0, rd); check("R2 count after write", rd, 32'd10);

    // arm and capture (R3)
    dump_i = make_dump(32'h0);
    access(1, 2'd1, 32'h1, rd);
    access(0, 2'd1, 0, rd); check("R3 armed", rd, 32'h1);
    pulse_sys();
    access(0, 2'd1, 0, rd); check("R4 enable cleared", rd, 32'h0);

    // table walk: R3 word select, R6 out of range
    for (int k = 0; k < NV; k++) begin
      access(1, 2'd1, {24'b0, VEC[k].idx, 4'b0}, rd);
      access(0, 2'd3, 0, rd);
      check(VEC[k].idx >= WORDS ? "R6 idx out of range" : "R3 word", rd, VEC[k].exp);
    end

    // R5: pulse with enable 0 keeps snapshot
    dump_i = make_dump(32'hFFFF_FFFF);
    pulse_sys();
    access(1, 2'd1, {24'b0, 4'd4, 4'b0}, rd);
    access(0, 2'd3, 0, rd); check("R5 snapshot kept", rd, pat(4));

    // R4: arm write and system reset in the same cycle
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 2'd1; req_wdata = {24'b0, 4'd2, 4'b0001};
    sys_rst_pulse = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; sys_rst_pulse = 0;
    access(0, 2'd1, 0, rd); check("R4 same-cycle enable", rd, 32'h20);
    access(0, 2'd3, 0, rd); check("R4 no capture", rd, pat(2));

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 2'd2;
    @(posedge clk);
    @(negedge clk);
    check("R9 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    check("R9 data", rsp_rdata, 32'd10);
    check("R9 req_ready low", {31'b0, req_ready}, 32'h0);
    req_addr = 2'd0;
    @(posedge clk);
    @(negedge clk);
    check("R9 data held", rsp_rdata, 32'd10);
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check("R9 queued request", rsp_rdata, 32'h1);

    // R7 / R8 lock
    access(1, 2'd1, {24'b0, 4'd6, 4'b0001}, rd);
    access(1, 2'd0, 32'h0, rd);
    access(0, 2'd0, 0, rd); check("R7 lock cleared", rd, 32'h0);
    access(1, 2'd0, 32'h1, rd);
    access(0, 2'd0, 0, rd); check("R7 lock stays 0", rd, 32'h0);
    access(1, 2'd1, {24'b0, 4'd1, 4'b0000}, rd);
    access(0, 2'd1, 0, rd); check("R8 ctrl ignored", rd, 32'h61);
    access(0, 2'd3, 0, rd); check("R8 index kept", rd, pat(6));
    // pulse still disarms while locked, and captures armed state
    dump_i = make_dump(32'h0000_00AA);
    pulse_sys();
    access(0, 2'd1, 0, rd); check("R4 clear while locked", rd, 32'h60);
    access(0, 2'd3, 0, rd); check("R3 capture while locked", rd, pat(6) ^ 32'hAA);

    // R1 again after block reset
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    access(0, 2'd0, 0, rd); check("R1 lock after reset", rd, 32'h1);
    access(0, 2'd3, 0, rd); check("R1 data after reset", rd, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule